// File: doc/BRIEF.md
# Command-Byte Register Front End

This block is the register-file side of a byte-oriented two-wire slave for a proximity sensor. It sits after the bit-level bus engine. That engine reports start and stop conditions, a match on the slave address together with the transfer direction, each received byte, and each request for a byte to send. From this stream the block decodes the command byte and keeps a 5-bit register pointer with its access mode. It then stores written bytes into the configuration registers and returns read bytes from the register map.

A command byte either loads the pointer or fires a one-shot special function. The only special function defined here clears the pending proximity interrupt. In repeat mode every access reuses the same address. In stepping mode the pointer advances after each access. Reads of the 16-bit proximity result go through a shadow latch, so the two bytes always belong to the same sample.

Top module: `cmdreg_front`

## Requirements
- R1: After reset, `prox_time` and `wait_time` are 0xFF, every other configuration output is 0, `int_clr` is 0 and `rd_data` is 0x00.
- R2: In a write transfer, a first byte with bit 7 set is a command: bits 6:5 give the kind (00 repeat, 01 step, 10 reserved, 11 special) and bits 4:0 give the address or code. Kinds 00 and 01 load the pointer and the mode, and the command byte itself writes no register.
- R3: In a write transfer, a first byte with bit 7 clear, and every byte after the first, is data stored at the current pointer.
- R4: In repeat mode the pointer is unchanged by reads and writes.
- R5: In step mode the pointer increments after every data write and every read, wrapping from 0x1F to 0x00.
- R6: A special command with code 00101 or 00111 drives `int_clr` high for exactly the one cycle after the byte. No other code pulses it. Special and reserved commands leave the pointer and mode unchanged.
- R7: A read request returns the byte at the pointer on `rd_data` one cycle later, and `rd_data` holds until the next accepted read. A read transfer without a new command uses the stored pointer.
- R8: A read of 0x18 returns `prox_data[7:0]` and captures `prox_data[15:8]`. A read of 0x19 returns the captured byte, even if `prox_data` has changed since.
- R9: Writable map: 0x00 (bit 0 `pwr_on`, bit 2 `prox_en`, bit 3 `wait_en`, bit 5 `int_en`); 0x02 `prox_time`; 0x03 `wait_time`; 0x08/0x09 `thr_low` low/high byte; 0x0A/0x0B `thr_high` low/high byte; 0x0C bits 7:4 `persist`; 0x0D bit 1 `wait_long`; 0x0E `pulse_count`; 0x0F bits 7:6 `led_drive`, 5:4 `diode_sel`, 3:2 `prox_gain`. Undefined bits store and read as 0.
- R10: 0x11 reads 0x01. 0x13 reads `prox_int_flag` at bit 5, `prox_valid_flag` at bit 1, and 0 in all other bits.
- R11: Writes to read-only or unmapped addresses change nothing. Reads of unmapped addresses return 0x00.
- R12: Bytes and read requests outside an addressed transfer of the matching direction are ignored. A transfer ends at start or stop and begins at `addr_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| addr_ok | input | 1 | Slave address matched (pulse) |
| addr_rd | input | 1 | Direction with `addr_ok`: 1 read, 0 write |
| rx_valid | input | 1 | Received byte valid (pulse) |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Engine requests the next byte to send |
| prox_data | input | 16 | Latest proximity result |
| prox_int_flag | input | 1 | Proximity interrupt pending |
| prox_valid_flag | input | 1 | Proximity result valid |
| rd_data | output | 8 | Byte to send |
| int_clr | output | 1 | One-cycle interrupt clear |
| pwr_on | output | 1 | Power enable |
| prox_en | output | 1 | Proximity enable |
| wait_en | output | 1 | Wait enable |
| int_en | output | 1 | Interrupt enable |
| prox_time | output | 8 | Integration time |
| wait_time | output | 8 | Wait time |
| thr_low | output | 16 | Lower threshold |
| thr_high | output | 16 | Upper threshold |
| persist | output | 4 | Persistence count |
| wait_long | output | 1 | Long wait scaling |
| pulse_count | output | 8 | LED pulse count |
| led_drive | output | 2 | LED drive code |
| diode_sel | output | 2 | Diode select code |
| prox_gain | output | 2 | Gain code |

## Verification
Every result lands one clock after the stimulus that caused it. A data byte shows on the configuration outputs after the edge that samples it. A read request loads `rd_data` at its sampling edge. A clearing command raises `int_clr` for the single cycle after its byte. The bench drives on the falling edge and advances its behavioural model just after the rising edge. It then compares every output with the model at the next falling edge, so each result is checked exactly one cycle after its cause. Directed checks, sampled just after the rising edge, pin down the values the requirements name, including the shadow byte, the pointer wrap and the pulse width.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;
    localparam int NREG   = 16;   // writable window 0x00..0x0F

    typedef logic [ADDR_W-1:0] regaddr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_REPEAT  = 2'b00,
        ACC_STEP    = 2'b01,
        ACC_RSVD    = 2'b10,
        ACC_SPECIAL = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic      is_cmd;
        acc_kind_e kind;
        regaddr_t  field;
    } cmd_t;

    localparam regaddr_t A_ENABLE  = 5'h00;
    localparam regaddr_t A_PTIME   = 5'h02;
    localparam regaddr_t A_WTIME   = 5'h03;
    localparam regaddr_t A_TLO_L   = 5'h08;
    localparam regaddr_t A_TLO_H   = 5'h09;
    localparam regaddr_t A_THI_L   = 5'h0A;
    localparam regaddr_t A_THI_H   = 5'h0B;
    localparam regaddr_t A_PERS    = 5'h0C;
    localparam regaddr_t A_CONFIG  = 5'h0D;
    localparam regaddr_t A_PULSES  = 5'h0E;
    localparam regaddr_t A_CONTROL = 5'h0F;
    localparam regaddr_t A_REV     = 5'h11;
    localparam regaddr_t A_STATUS  = 5'h13;
    localparam regaddr_t A_PDAT_L  = 5'h18;
    localparam regaddr_t A_PDAT_H  = 5'h19;

    localparam byte_t REV_CODE = 8'h01;

    function automatic cmd_t split_cmd(byte_t b);
        cmd_t c;
        c.is_cmd = b[7];
        c.kind   = acc_kind_e'(b[6:5]);
        c.field  = b[4:0];
        return c;
    endfunction

    // bits that hold state; zero mask means not writable
    function automatic byte_t wr_mask(regaddr_t a);
        case (a)
            A_ENABLE:  return 8'h2D;
            A_PTIME,
            A_WTIME,
            A_TLO_L,
            A_TLO_H,
            A_THI_L,
            A_THI_H,
            A_PULSES:  return 8'hFF;
            A_PERS:    return 8'hF0;
            A_CONFIG:  return 8'h02;
            A_CONTROL: return 8'hFC;
            default:   return 8'h00;
        endcase
    endfunction

    function automatic byte_t reset_val(regaddr_t a);
        return (a == A_PTIME || a == A_WTIME) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic is_clear_code(regaddr_t c);
        return (c == 5'b00101) || (c == 5'b00111);
    endfunction

endpackage

// File: rtl/cmd_front.sv
module cmd_front
    import cmdreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_start,
    input  logic      bus_stop,
    input  logic      addr_ok,
    input  logic      addr_rd,
    input  logic      rx_valid,
    input  byte_t     rx_byte,
    input  logic      rd_req,
    output logic      wr_en,
    output regaddr_t  acc_addr,
    output byte_t     wr_data,
    output logic      rd_fire,
    output acc_kind_e cur_mode,
    output logic      clr_pulse
);

    logic      active_q;
    logic      dir_rd_q;
    logic      first_q;
    regaddr_t  ptr_q;
    acc_kind_e mode_q;
    logic      clr_q;

    cmd_t cmd;
    logic byte_ok;
    logic take_cmd;
    logic step_now;
    logic load_ptr;

    always_comb begin
        cmd      = split_cmd(rx_byte);
        byte_ok  = active_q && !dir_rd_q && rx_valid;
        take_cmd = byte_ok && first_q && cmd.is_cmd;
        wr_en    = byte_ok && !take_cmd;
        rd_fire  = active_q && dir_rd_q && rd_req;
        step_now = (wr_en || rd_fire) && (mode_q == ACC_STEP);
        load_ptr = take_cmd && (cmd.kind == ACC_REPEAT || cmd.kind == ACC_STEP);
    end

    // transfer tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            dir_rd_q <= 1'b0;
            first_q  <= 1'b0;
        end else if (addr_ok) begin
            active_q <= 1'b1;
            dir_rd_q <= addr_rd;
            first_q  <= !addr_rd;
        end else if (bus_start || bus_stop) begin
            active_q <= 1'b0;
            first_q  <= 1'b0;
        end else if (byte_ok) begin
            first_q  <= 1'b0;
        end
    end

    // pointer, mode and special function
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            mode_q <= ACC_REPEAT;
            clr_q  <= 1'b0;
        end else begin
            clr_q <= take_cmd && (cmd.kind == ACC_SPECIAL) && is_clear_code(cmd.field);
            if (load_ptr) begin
                ptr_q  <= cmd.field;
                mode_q <= cmd.kind;
            end else if (step_now) begin
                ptr_q  <= ptr_q + regaddr_t'(1);
            end
        end
    end

    assign acc_addr  = ptr_q;
    assign wr_data   = rx_byte;
    assign cur_mode  = mode_q;
    assign clr_pulse = clr_q;

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cmdreg_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  regaddr_t          wr_addr,
    input  byte_t             wr_data,
    output logic [N*BYTE_W-1:0] regs_flat
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam regaddr_t MY_ADDR = regaddr_t'(i);
        localparam byte_t    MY_MASK = wr_mask(MY_ADDR);
        byte_t r_q;

        if (MY_MASK == 8'h00) begin : g_hole
            assign r_q = 8'h00;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst)
                    r_q <= reset_val(MY_ADDR);
                else if (wr_en && wr_addr == MY_ADDR)
                    r_q <= wr_data & MY_MASK;
            end
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = r_q;
    end

endmodule

// File: rtl/rd_path.sv
module rd_path
    import cmdreg_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_fire,
    input  regaddr_t            rd_addr,
    input  logic [N*BYTE_W-1:0] regs_flat,
    input  logic [2*BYTE_W-1:0] prox_data,
    input  logic                prox_int_flag,
    input  logic                prox_valid_flag,
    output byte_t               rd_data,
    output byte_t               shadow
);

    byte_t rd_q;
    byte_t sh_q;
    byte_t sel;

    always_comb begin
        if (int'(rd_addr) < N) begin
            sel = regs_flat[int'(rd_addr)*BYTE_W +: BYTE_W];
        end else begin
            case (rd_addr)
                A_REV:    sel = REV_CODE;
                A_STATUS: sel = {2'b00, prox_int_flag, 3'b000, prox_valid_flag, 1'b0};
                A_PDAT_L: sel = prox_data[BYTE_W-1:0];
                A_PDAT_H: sel = sh_q;
                default:  sel = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 8'h00;
            sh_q <= 8'h00;
        end else if (rd_fire) begin
            rd_q <= sel;
            if (rd_addr == A_PDAT_L)
                sh_q <= prox_data[2*BYTE_W-1:BYTE_W];
        end
    end

    assign rd_data = rd_q;
    assign shadow  = sh_q;

endmodule

// File: rtl/cmdreg_front.sv
module cmdreg_front
    import cmdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        addr_ok,
    input  logic        addr_rd,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rd_req,
    input  logic [15:0] prox_data,
    input  logic        prox_int_flag,
    input  logic        prox_valid_flag,
    output logic [7:0]  rd_data,
    output logic        int_clr,
    output logic        pwr_on,
    output logic        prox_en,
    output logic        wait_en,
    output logic        int_en,
    output logic [7:0]  prox_time,
    output logic [7:0]  wait_time,
    output logic [15:0] thr_low,
    output logic [15:0] thr_high,
    output logic [3:0]  persist,
    output logic        wait_long,
    output logic [7:0]  pulse_count,
    output logic [1:0]  led_drive,
    output logic [1:0]  diode_sel,
    output logic [1:0]  prox_gain
);

    localparam int W = BYTE_W;

    logic      wr_en;
    regaddr_t  acc_addr;
    byte_t     wr_data;
    logic      rd_fire;
    acc_kind_e cur_mode;
    byte_t     shadow_q;
    logic [NREG*W-1:0] regs_flat;

    cmd_front u_front (
        .clk       (clk),
        .rst       (rst),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_ok   (addr_ok),
        .addr_rd   (addr_rd),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rd_req    (rd_req),
        .wr_en     (wr_en),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .rd_fire   (rd_fire),
        .cur_mode  (cur_mode),
        .clr_pulse (int_clr)
    );

    cfg_bank #(.N(NREG)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (acc_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    rd_path #(.N(NREG)) u_rd (
        .clk             (clk),
        .rst             (rst),
        .rd_fire         (rd_fire),
        .rd_addr         (acc_addr),
        .regs_flat       (regs_flat),
        .prox_data       (prox_data),
        .prox_int_flag   (prox_int_flag),
        .prox_valid_flag (prox_valid_flag),
        .rd_data         (rd_data),
        .shadow          (shadow_q)
    );

    function automatic byte_t pick(logic [NREG*W-1:0] f, regaddr_t a);
        return f[int'(a)*W +: W];
    endfunction

    byte_t en_b, pers_b, cfg_b, ctl_b;

    always_comb begin
        en_b   = pick(regs_flat, A_ENABLE);
        pers_b = pick(regs_flat, A_PERS);
        cfg_b  = pick(regs_flat, A_CONFIG);
        ctl_b  = pick(regs_flat, A_CONTROL);

        pwr_on      = en_b[0];
        prox_en     = en_b[2];
        wait_en     = en_b[3];
        int_en      = en_b[5];
        prox_time   = pick(regs_flat, A_PTIME);
        wait_time   = pick(regs_flat, A_WTIME);
        thr_low     = {pick(regs_flat, A_TLO_H), pick(regs_flat, A_TLO_L)};
        thr_high    = {pick(regs_flat, A_THI_H), pick(regs_flat, A_THI_L)};
        persist     = pers_b[7:4];
        wait_long   = cfg_b[1];
        pulse_count = pick(regs_flat, A_PULSES);
        led_drive   = ctl_b[7:6];
        diode_sel   = ctl_b[5:4];
        prox_gain   = ctl_b[3:2];
    end

endmodule

// File: rtl/cmdreg_front_chk.sv
module cmdreg_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        int_clr,
    input logic        wr_en,
    input logic        rd_fire,
    input logic [4:0]  acc_addr,
    input logic [1:0]  cur_mode,
    input logic [7:0]  rd_data,
    input logic [7:0]  shadow_q,
    input logic [15:0] prox_data,
    input logic [7:0]  prox_time,
    input logic [7:0]  wait_time,
    input logic [15:0] thr_low
);

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        int_clr |=> !int_clr); // R6

    AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_fire) && cur_mode == 2'b00) |=> $stable(acc_addr)); // R4

    AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_fire) && cur_mode == 2'b01) |=> acc_addr == $past(acc_addr) + 5'd1); // R5

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && acc_addr == 5'h18) |=> shadow_q == $past(prox_data[15:8])); // R8

    AST_REV_VALUE: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && acc_addr == 5'h11) |=> rd_data == 8'h01); // R10

    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_addr > 5'h0F) |=> ($stable(prox_time) && $stable(wait_time) && $stable(thr_low))); // R11

endmodule

bind cmdreg_front cmdreg_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .int_clr   (int_clr),
    .wr_en     (wr_en),
    .rd_fire   (rd_fire),
    .acc_addr  (acc_addr),
    .cur_mode  (cur_mode),
    .rd_data   (rd_data),
    .shadow_q  (shadow_q),
    .prox_data (prox_data),
    .prox_time (prox_time),
    .wait_time (wait_time),
    .thr_low   (thr_low)
);

// File: tb/test_cmdreg_front.sv
`timescale 1ns/1ps
module test_cmdreg_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_start = 0, bus_stop = 0, addr_ok = 0, addr_rd = 0;
    logic        rx_valid = 0, rd_req = 0;
    logic [7:0]  rx_byte = 0;
    logic [15:0] prox_data = 0;
    logic        prox_int_flag = 0, prox_valid_flag = 0;
    logic [7:0]  rd_data;
    logic        int_clr, pwr_on, prox_en, wait_en, int_en, wait_long;
    logic [7:0]  prox_time, wait_time, pulse_count;
    logic [15:0] thr_low, thr_high;
    logic [3:0]  persist;
    logic [1:0]  led_drive, diode_sel, prox_gain;

    always #2.5 clk = ~clk;

    cmdreg_front i_cmdreg_front (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_ok(addr_ok), .addr_rd(addr_rd), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_req(rd_req), .prox_data(prox_data), .prox_int_flag(prox_int_flag),
        .prox_valid_flag(prox_valid_flag), .rd_data(rd_data), .int_clr(int_clr),
        .pwr_on(pwr_on), .prox_en(prox_en), .wait_en(wait_en), .int_en(int_en),
        .prox_time(prox_time), .wait_time(wait_time), .thr_low(thr_low),
        .thr_high(thr_high), .persist(persist), .wait_long(wait_long),
        .pulse_count(pulse_count), .led_drive(led_drive), .diode_sel(diode_sel),
        .prox_gain(prox_gain)
    );

    int nchk = 0;
    int nerr = 0;
    bit running = 0;
    bit done = 0;

    // behavioural model
    logic [7:0] mreg [32];
    int  mptr, mmode;
    bit  mact, mdir, mfirst, mclr;
    logic [7:0] mrd, msh;

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] keep_bits(int a);
        case (a)
            0: return 8'h2D;
            2, 3, 8, 9, 10, 11, 14: return 8'hFF;
            12: return 8'hF0;
            13: return 8'h02;
            15: return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] model_read(int a);
        if (a < 16) return mreg[a];
        if (a == 'h11) return 8'h01;
        if (a == 'h13) return {2'b00, prox_int_flag, 3'b000, prox_valid_flag, 1'b0};
        if (a == 'h18) return prox_data[7:0];
        if (a == 'h19) return msh;
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
        mreg[2] = 8'hFF; mreg[3] = 8'hFF;
        mptr = 0; mmode = 0; mact = 0; mdir = 0; mfirst = 0; mclr = 0;
        mrd = 0; msh = 0;
    endtask

    // one clock: 0 idle, 1 start, 2 stop, 3 addr, 4 byte, 5 read
    task automatic tick(int kind, logic [7:0] val);
        @(negedge clk);
        bus_start = (kind == 1); bus_stop = (kind == 2);
        addr_ok = (kind == 3); addr_rd = val[0];
        rx_valid = (kind == 4); rx_byte = val;
        rd_req = (kind == 5);
        @(posedge clk);
        #1;
        mclr = 0;
        case (kind)
            1, 2: begin mact = 0; mfirst = 0; end
            3: begin mact = 1; mdir = val[0]; mfirst = !val[0]; end
            4: if (mact && !mdir) begin
                if (mfirst && val[7]) begin
                    if (val[6:5] == 2'b00 || val[6:5] == 2'b01) begin
                        mptr = val[4:0]; mmode = val[6:5];
                    end else if (val[6:5] == 2'b11 && (val[4:0] == 5 || val[4:0] == 7)) begin
                        mclr = 1;
                    end
                end else begin
                    mreg[mptr] = val & keep_bits(mptr);
                    if (mmode == 1) mptr = (mptr + 1) % 32;
                end
                mfirst = 0;
            end
            5: if (mact && mdir) begin
                mrd = model_read(mptr);
                if (mptr == 'h18) msh = prox_data[15:8];
                if (mmode == 1) mptr = (mptr + 1) % 32;
            end
            default: ;
        endcase
        bus_start = 0; bus_stop = 0; addr_ok = 0; rx_valid = 0; rd_req = 0;
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (running && !done) begin
            check("R7 rd_data", rd_data, mrd);
            check("R6 int_clr", int_clr, mclr);
            check("R9 enable", {int_en, wait_en, prox_en, pwr_on},
                  {mreg[0][5], mreg[0][3], mreg[0][2], mreg[0][0]});
            check("R9 prox_time", prox_time, mreg[2]);
            check("R9 wait_time", wait_time, mreg[3]);
            check("R9 thr_low", thr_low, {mreg[9], mreg[8]});
            check("R9 thr_high", thr_high, {mreg[11], mreg[10]});
            check("R9 persist", persist, mreg[12][7:4]);
            check("R9 wait_long", wait_long, mreg[13][1]);
            check("R9 pulse_count", pulse_count, mreg[14]);
            check("R9 control", {led_drive, diode_sel, prox_gain}, mreg[15][7:2]);
        end
    end

    task automatic wr_txn(logic [7:0] b0);
        tick(1, 0); tick(3, 8'h00); tick(4, b0);
    endtask

    task automatic rd_start();
        tick(1, 0); tick(3, 8'h01);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst = 0;
        running = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 prox_time", prox_time, 8'hFF);
        check("R1 wait_time", wait_time, 8'hFF);
        check("R1 thr_low", thr_low, 0);
        check("R1 pwr_on", pwr_on, 0);
        check("R1 rd_data", rd_data, 0);

        // R2/R3/R11: step write from 0x00 through an unmapped hole
        wr_txn(8'hA0);
        check("R2 command writes nothing", pwr_on, 0);
        tick(4, 8'hFF); tick(4, 8'h11); tick(4, 8'h33); tick(4, 8'h44); tick(2, 0);
        check("R9 enable bits", {int_en, wait_en, prox_en, pwr_on}, 4'hF);
        check("R3 prox_time", prox_time, 8'h33);
        check("R5 wait_time", wait_time, 8'h44);

        // R4 repeat mode overwrites one register
        wr_txn(8'h88); tick(4, 8'h12); tick(4, 8'h34); tick(2, 0);
        check("R4 thr_low", thr_low, 16'h0034);

        // R3 first byte without bit 7 is data at last pointer
        wr_txn(8'h56); tick(2, 0);
        check("R3 thr_low", thr_low, 16'h0056);

        // R9 fill thresholds and control fields
        wr_txn(8'hA8);
        tick(4, 8'h01); tick(4, 8'h02); tick(4, 8'h03); tick(4, 8'h04);
        tick(4, 8'hF7); tick(4, 8'hFF); tick(4, 8'h10); tick(4, 8'hFF); tick(2, 0);
        check("R9 thr_low", thr_low, 16'h0201);
        check("R9 thr_high", thr_high, 16'h0403);
        check("R9 persist", persist, 4'hF);
        check("R9 wait_long", wait_long, 1);
        check("R9 led_drive", led_drive, 3);

        // R10 revision, repeated read
        wr_txn(8'h91); rd_start(); tick(5, 0);
        check("R10 rev", rd_data, 8'h01);
        tick(5, 0);
        check("R4 repeat read", rd_data, 8'h01);
        tick(2, 0);

        // R10 status bits
        prox_int_flag = 1; prox_valid_flag = 1;
        wr_txn(8'h93); rd_start(); tick(5, 0); tick(2, 0);
        check("R10 status", rd_data, 8'h22);

        // R8 shadow coherence
        prox_data = 16'hABCD;
        wr_txn(8'hB8); rd_start(); tick(5, 0);
        check("R8 low byte", rd_data, 8'hCD);
        prox_data = 16'h1234;
        tick(0, 0); tick(5, 0);
        check("R8 shadow byte", rd_data, 8'hAB);
        tick(2, 0);
        wr_txn(8'h99); rd_start(); tick(5, 0); tick(2, 0);
        check("R8 shadow held", rd_data, 8'hAB);

        // R11 unmapped read, write to read-only
        wr_txn(8'h85); rd_start(); tick(5, 0); tick(2, 0);
        check("R11 unmapped read", rd_data, 8'h00);
        wr_txn(8'h91); tick(4, 8'h77); rd_start(); tick(5, 0); tick(2, 0);
        check("R11 rev unchanged", rd_data, 8'h01);

        // R5 wrap from 0x1F to 0x00
        wr_txn(8'hBF); tick(4, 8'hEE); tick(4, 8'h5A); tick(2, 0);
        check("R5 wrap enable", {int_en, wait_en, prox_en, pwr_on}, 4'b0100);

        // R6 special functions and reserved kind
        wr_txn(8'h82); tick(2, 0);
        wr_txn(8'hE5);
        check("R6 clear pulse", int_clr, 1);
        tick(0, 0);
        check("R6 clear single", int_clr, 0);
        tick(2, 0);
        wr_txn(8'hE7);
        check("R6 alt clear code", int_clr, 1);
        tick(2, 0);
        wr_txn(8'hE3);
        check("R6 no pulse other code", int_clr, 0);
        tick(2, 0);
        wr_txn(8'hC3); tick(2, 0);
        rd_start(); tick(5, 0); tick(2, 0);
        check("R7 stored pointer", rd_data, 8'h33);

        // R12 activity outside a transfer
        tick(4, 8'h00); tick(5, 0);
        check("R12 byte ignored", prox_time, 8'h33);
        check("R12 read ignored", rd_data, 8'h33);
        rd_start(); tick(4, 8'h00); tick(2, 0);
        check("R12 byte in read transfer", prox_time, 8'h33);

        repeat (3) tick(0, 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule